// File: doc/BRIEF.md
# Warp Operand Base-Delta Compressor

This block sits in front of the write port of a banked register file and shrinks one warp operand before it is stored. An operand has 32 lanes of 32 bits, 128 bytes in all, and normally fills eight 16-byte bank slices. Lane 0 is kept unchanged as the base. Each of the other lanes is reduced to its difference from that base. When all differences are zero, or all fit in a signed byte or a signed halfword, the block emits a packed image of the base followed by the narrow deltas. It also emits a 2-bit encoding and the number of 16-byte slices the image fills, so that the unused banks need not be touched.

If the differences are too wide, the operand passes through raw. The same happens when the compression enable is low, which is the case for a warp with inactive lanes. The block is a two-stage pipeline. It accepts a new operand on every cycle, and its valid flag travels with the data.

Top module: `wop_bd_compressor`

## Requirements
- R1: `valid_out` rises exactly two clock cycles after an accepted `valid_in`, and it is never high unless an operand was presented two cycles earlier.
- R2: In every compressed encoding, `data_out[31:0]` equals lane 0 of the input (input bits 31:0) unchanged.
- R3: When every lane equals lane 0, `enc_out` is 2'b00, `banks_out` is 1, and all bits of `data_out` above bit 31 are zero.
- R4: When every difference fits a signed 8-bit value and not all are zero, `enc_out` is 2'b01 and `banks_out` is 3. The low byte of lane i's difference sits at output byte 4+(i-1), where byte n is bits 8n+7:8n, and output bytes 35 and up are zero.
- R5: When every difference fits a signed 16-bit value but some do not fit 8 bits, `enc_out` is 2'b10 and `banks_out` is 5. The low halfword of lane i's difference sits at output bytes 4+2(i-1) (low byte) and 5+2(i-1), and output bytes 66 and up are zero.
- R6: When some difference lies outside the signed 16-bit range, `enc_out` is 2'b11, `banks_out` is 8 and `data_out` equals the input operand.
- R7: When `comp_en` is low for an operand, the result is 2'b11 with 8 banks and raw data, whatever the lane values are.
- R8: A difference is lane minus lane 0 modulo 2^32, taken as signed. The ranges -128..127 and -32768..32767 both include their end points.
- R9: The narrowest encoding that every lane satisfies is chosen, in the order 0-byte, 1-byte, 2-byte, raw.
- R10: Operands presented on consecutive cycles all produce results, in order. Idle cycles in the input produce no results.
- R11: While reset is held and right after it is released, `valid_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Operand present this cycle |
| comp_en | input | 1 | Compression allowed (low for a warp with inactive lanes) |
| data_in | input | 1024 | Operand, lane i in bits 32i+31:32i |
| valid_out | output | 1 | Result present this cycle |
| enc_out | output | 2 | 00 zero delta, 01 byte delta, 10 halfword delta, 11 raw |
| banks_out | output | 4 | Number of 16-byte slices the result fills |
| data_out | output | 1024 | Packed image, or raw operand |

## Verification
The bench targets the exact edges of the signed ranges. Deltas of +127 and -128 must stay at one byte, and +128 must promote to two bytes. Likewise, -32768 and +32767 must stay at two bytes, and +32768 must fall back to raw. An off-by-one or unsigned range test would pick the wrong width at one of these points. A base of all ones with lanes of zero checks that the difference wraps modulo 2^32 instead of being flagged as too wide. Operands with the enable low but perfectly compressible values must still come out raw. A design that ignored the enable would emit a packed image that the write path cannot merge by lane. Back-to-back operands with a bubble between them catch a pipeline that stalls, duplicates or drops a result, or that lets a stale valid through.

// File: rtl/wbd_pkg.sv
package wbd_pkg;
    parameter int LANES       = 32;
    parameter int LANE_W      = 32;
    parameter int SLICE_BYTES = 16;
    parameter int NARROW_W    = 8;
    parameter int WIDE_W      = 16;

    typedef enum logic [1:0] {
        ENC_D0  = 2'b00,
        ENC_D1  = 2'b01,
        ENC_D2  = 2'b10,
        ENC_RAW = 2'b11
    } enc_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/bd_lane_fit.sv
module bd_lane_fit #(
    parameter int LANE_W   = 32,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic [LANE_W-1:0] base_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic              zero_o,
    output logic              fit_n_o,
    output logic              fit_w_o,
    output logic [WIDE_W-1:0] delta_o
);
    logic [LANE_W-1:0] diff;

    always_comb begin
        diff    = lane_i - base_i;
        zero_o  = (diff == '0);
        // fits when the bits above the field repeat the field's sign bit
        fit_n_o = (&diff[LANE_W-1:NARROW_W-1]) | ~(|diff[LANE_W-1:NARROW_W-1]);
        fit_w_o = (&diff[LANE_W-1:WIDE_W-1])   | ~(|diff[LANE_W-1:WIDE_W-1]);
        delta_o = diff[WIDE_W-1:0];
    end
endmodule

// File: rtl/bd_packer.sv
module bd_packer
    import wbd_pkg::*;
#(
    parameter int LANES    = 32,
    parameter int LANE_W   = 32,
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    localparam int OP_W    = LANES * LANE_W,
    localparam int DL_W    = (LANES - 1) * WIDE_W
) (
    input  enc_e            enc_i,
    input  logic [OP_W-1:0] raw_i,
    input  logic [DL_W-1:0] delta_i,
    output logic [OP_W-1:0] packed_o
);
    always_comb begin
        packed_o = '0;
        if (enc_i == ENC_RAW) begin
            packed_o = raw_i;
        end else begin
            packed_o[LANE_W-1:0] = raw_i[LANE_W-1:0];
            for (int i = 1; i < LANES; i++) begin
                if (enc_i == ENC_D1)
                    packed_o[LANE_W + (i-1)*NARROW_W +: NARROW_W] =
                        delta_i[(i-1)*WIDE_W +: NARROW_W];
                else if (enc_i == ENC_D2)
                    packed_o[LANE_W + (i-1)*WIDE_W +: WIDE_W] =
                        delta_i[(i-1)*WIDE_W +: WIDE_W];
            end
        end
    end
endmodule

// File: rtl/wop_bd_compressor.sv
module wop_bd_compressor
    import wbd_pkg::*;
#(
    parameter int LANES       = wbd_pkg::LANES,
    parameter int LANE_W      = wbd_pkg::LANE_W,
    parameter int SLICE_BYTES = wbd_pkg::SLICE_BYTES,
    parameter int NARROW_W    = wbd_pkg::NARROW_W,
    parameter int WIDE_W      = wbd_pkg::WIDE_W,
    localparam int OP_W       = LANES * LANE_W,
    localparam int BASE_B     = LANE_W / 8,
    localparam int OP_B       = OP_W / 8,
    localparam int D1_B       = BASE_B + (LANES - 1) * (NARROW_W / 8),
    localparam int D2_B       = BASE_B + (LANES - 1) * (WIDE_W / 8),
    localparam int BANKS_MAX  = ceil_div(OP_B, SLICE_BYTES),
    localparam int BANK_W     = $clog2(BANKS_MAX + 1),
    localparam int DL_W       = (LANES - 1) * WIDE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic              comp_en,
    input  logic [OP_W-1:0]   data_in,
    output logic              valid_out,
    output logic [1:0]        enc_out,
    output logic [BANK_W-1:0] banks_out,
    output logic [OP_W-1:0]   data_out
);
    localparam logic [BANK_W-1:0] BK_D0  = BANK_W'(ceil_div(BASE_B, SLICE_BYTES));
    localparam logic [BANK_W-1:0] BK_D1  = BANK_W'(ceil_div(D1_B, SLICE_BYTES));
    localparam logic [BANK_W-1:0] BK_D2  = BANK_W'(ceil_div(D2_B, SLICE_BYTES));
    localparam logic [BANK_W-1:0] BK_RAW = BANK_W'(BANKS_MAX);

    typedef struct packed {
        logic              valid;
        logic              en;
        logic [OP_W-1:0]   data;
        logic [LANES-1:1]  f0;
        logic [LANES-1:1]  f1;
        logic [LANES-1:1]  f2;
        logic [DL_W-1:0]   dlo;
    } s1_t;

    typedef struct packed {
        logic              valid;
        enc_e              enc;
        logic [BANK_W-1:0] banks;
        logic [OP_W-1:0]   data;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    logic [LANES-1:1] f0_w, f1_w, f2_w;
    logic [DL_W-1:0]  dlo_w;
    enc_e             enc_sel;
    logic [OP_W-1:0]  packed_w;

    // stage 1: one subtractor and range check per non-base lane
    for (genvar g = 1; g < LANES; g++) begin : g_lane
        bd_lane_fit #(
            .LANE_W   (LANE_W),
            .NARROW_W (NARROW_W),
            .WIDE_W   (WIDE_W)
        ) u_fit (
            .base_i  (data_in[LANE_W-1:0]),
            .lane_i  (data_in[g*LANE_W +: LANE_W]),
            .zero_o  (f0_w[g]),
            .fit_n_o (f1_w[g]),
            .fit_w_o (f2_w[g]),
            .delta_o (dlo_w[(g-1)*WIDE_W +: WIDE_W])
        );
    end

    bd_packer #(
        .LANES    (LANES),
        .LANE_W   (LANE_W),
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W)
    ) u_pack (
        .enc_i    (enc_sel),
        .raw_i    (s1_q.data),
        .delta_i  (s1_q.dlo),
        .packed_o (packed_w)
    );

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = valid_in;
        s1_d.en    = comp_en;
        s1_d.data  = data_in;
        s1_d.f0    = f0_w;
        s1_d.f1    = f1_w;
        s1_d.f2    = f2_w;
        s1_d.dlo   = dlo_w;

        // stage 2: narrowest width met by every lane, then pack
        if (!s1_q.en)       enc_sel = ENC_RAW;
        else if (&s1_q.f0)  enc_sel = ENC_D0;
        else if (&s1_q.f1)  enc_sel = ENC_D1;
        else if (&s1_q.f2)  enc_sel = ENC_D2;
        else                enc_sel = ENC_RAW;

        s2_d       = s2_q;
        s2_d.valid = s1_q.valid;
        s2_d.enc   = enc_sel;
        s2_d.data  = packed_w;
        unique case (enc_sel)
            ENC_D0:  s2_d.banks = BK_D0;
            ENC_D1:  s2_d.banks = BK_D1;
            ENC_D2:  s2_d.banks = BK_D2;
            default: s2_d.banks = BK_RAW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '{valid: 1'b0, enc: ENC_RAW, banks: '0, data: '0};
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign valid_out = s2_q.valid;
    assign enc_out   = s2_q.enc;
    assign banks_out = s2_q.banks;
    assign data_out  = s2_q.data;

    // cycles since reset release, saturating, so $past never reaches before reset
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (valid_out == $past(valid_in, 2)));

    p_base_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && valid_out && enc_out != 2'b11)
            |-> (data_out[LANE_W-1:0] == $past(data_in[LANE_W-1:0], 2)));

    p_zero_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && enc_out == 2'b00)
            |-> (banks_out == BK_D0 && data_out[OP_W-1:LANE_W] == '0));

    p_byte_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && enc_out == 2'b01)
            |-> (banks_out == BK_D1 && data_out[OP_W-1:D1_B*8] == '0));

    p_half_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && enc_out == 2'b10)
            |-> (banks_out == BK_D2 && data_out[OP_W-1:D2_B*8] == '0));

    p_raw_banks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && enc_out == 2'b11) |-> (banks_out == BK_RAW));

    p_disabled_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2 && valid_out && !$past(comp_en, 2))
            |-> (enc_out == 2'b11 && data_out == $past(data_in, 2)));
endmodule

// File: tb/test_wop_bd_compressor.sv
module test_wop_bd_compressor;
    localparam int NL = 32;
    localparam int OW = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_in = 1'b0;
    logic          comp_en = 1'b1;
    logic [OW-1:0] data_in = '0;
    logic          valid_out;
    logic [1:0]    enc_out;
    logic [3:0]    banks_out;
    logic [OW-1:0] data_out;

    wop_bd_compressor i_wop_bd_compressor (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .comp_en   (comp_en),
        .data_in   (data_in),
        .valid_out (valid_out),
        .enc_out   (enc_out),
        .banks_out (banks_out),
        .data_out  (data_out)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [1:0]    enc;
        logic [3:0]    banks;
        logic [OW-1:0] data;
        int            cyc;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   done   = 1'b0;
    logic [31:0] ln [NL];

    always @(posedge clk) cyc <= cyc + 1;

    // independent model: signed integer ranges, byte-by-byte packing
    function automatic exp_t model(input logic [OW-1:0] d, input logic en);
        exp_t e;
        bit f0 = 1, f1 = 1, f2 = 1;
        int k, nb;
        logic [31:0] dv [NL];
        for (int i = 1; i < NL; i++) begin
            int s;
            dv[i] = d[i*32 +: 32] - d[31:0];
            s = $signed(dv[i]);
            if (s != 0) f0 = 0;
            if (s < -128 || s > 127) f1 = 0;
            if (s < -32768 || s > 32767) f2 = 0;
        end
        if (!en)     k = -1;
        else if (f0) k = 0;
        else if (f1) k = 1;
        else if (f2) k = 2;
        else         k = -1;
        e.data = '0;
        if (k < 0) begin
            e.enc = 2'b11; nb = 128; e.data = d;
        end else begin
            e.enc = 2'(k);
            nb = 4 + 31 * k;
            e.data[31:0] = d[31:0];
            for (int i = 1; i < NL; i++)
                for (int b = 0; b < k; b++)
                    e.data[(4 + (i-1)*k + b)*8 +: 8] = dv[i][b*8 +: 8];
        end
        e.banks = 4'((nb + 15) / 16);
        return e;
    endfunction

    function automatic logic [OW-1:0] pack_lanes();
        logic [OW-1:0] r;
        for (int i = 0; i < NL; i++) r[i*32 +: 32] = ln[i];
        return r;
    endfunction

    task automatic send(input logic en, input string tag);
        exp_t e;
        @(negedge clk);
        valid_in = 1'b1;
        comp_en  = en;
        data_in  = pack_lanes();
        e     = model(data_in, en);
        e.cyc = cyc;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        valid_in = 1'b0;
        data_in  = '0;
    endtask

    task automatic fill(input logic [31:0] base, input int step);
        for (int i = 0; i < NL; i++) ln[i] = base + 32'(i * step);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && valid_out && !done) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R10: unexpected result enc=%b actual valid_out=1 expected 0", enc_out);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (enc_out !== e.enc || banks_out !== e.banks || data_out !== e.data
                    || (cyc - e.cyc) != 2) begin
                    fails++;
                    $display("FAIL %s R1: actual enc=%b banks=%0d lat=%0d data=%h expected enc=%b banks=%0d lat=2 data=%h",
                             e.tag, enc_out, banks_out, cyc - e.cyc, data_out,
                             e.enc, e.banks, e.data);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (valid_out !== 1'b0) begin
            fails++;
            $display("FAIL R11: actual valid_out=%b expected 0 in reset", valid_out);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (valid_out !== 1'b0) begin
            fails++;
            $display("FAIL R11: actual valid_out=%b expected 0 after reset", valid_out);
        end

        // R3 R9: constant operand
        fill(32'd5, 0);                send(1'b1, "R3_const");
        // R4 R2: index values, back to back (R10)
        fill(32'd1000, 1);             send(1'b1, "R4_index");
        // R8: byte boundaries inclusive
        fill(32'h1234_5678, 0);
        ln[31] = ln[0] + 32'd127; ln[5] = ln[0] - 32'd128;
        send(1'b1, "R8_byte_edge");
        // R8 R5: +128 promotes to halfword
        ln[7] = ln[0] + 32'd128;       send(1'b1, "R5_plus128");
        idle();                        // bubble R10
        // R5 R8: halfword boundaries inclusive
        fill(32'h8000_0000, 0);
        ln[1] = ln[0] - 32'd32768; ln[30] = ln[0] + 32'd32767;
        send(1'b1, "R5_half_edge");
        // R6: +32768 falls back to raw
        ln[12] = ln[0] + 32'd32768;    send(1'b1, "R6_too_wide");
        // R8: wrap modulo 2^32
        fill(32'hFFFF_FFFF, 0);
        for (int i = 1; i < NL; i++) ln[i] = 32'(i - 1);
        send(1'b1, "R8_wrap");
        // R7: enable low, compressible values
        fill(32'd7, 0);                send(1'b0, "R7_const_off");
        fill(32'd50, 2);               send(1'b0, "R7_index_off");
        // R9: same data enabled again picks the byte width
        send(1'b1, "R9_index_on");
        idle(); idle();
        // R5: negative halfword stride
        fill(32'd100000, -1000);       send(1'b1, "R5_neg_stride");
        // R6 R10: random operands back to back
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < NL; i++) ln[i] = $urandom;
            send(1'b1, "R6_random");
        end
        // R4: random small deltas around a random base
        for (int r = 0; r < 3; r++) begin
            ln[0] = $urandom;
            for (int i = 1; i < NL; i++) ln[i] = ln[0] + 32'($signed(8'($urandom)));
            ln[9] = ln[0] + 32'd3;
            send(1'b1, "R4_random_small");
        end
        idle();
        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R10: actual %0d results missing expected 0", q.size());
        end
        finish_run();
    end
endmodule